// File: doc/BRIEF.md
# Burst-of-Four DDR SRAM Command Scheduler

This block sits on the controller side of a common-I/O DDR SRAM that moves four data beats for every address it loads. Users present whole-burst requests through a valid/ready handshake. A request carries a burst address, a read/write flag and, for writes, all four beats at once. The block turns each accepted request into one command on the memory pins. It places the write beat pairs in the late-write slots that follow that command, and it returns read beat pairs to the user in command order, each pair with a valid strobe.

The memory ignores its control pins in the cycle after a load, so the scheduler never places two loads in adjacent cycles. Reads and writes use the same data bus. Before a write that follows a read, the scheduler holds writes back until the read's data has left the bus and one idle cycle has passed. When it has no accepted request it drives deselect.

The memory bus is modelled one K cycle per clock. Each data word on the memory side is a pair of beats, and the double-rate serialisation is left to a separate physical layer.

Top module: `qb4_sched`

## Requirements
- R1: While `rst` is high, `mem_ld_n` is 1, `mem_wdata_oe` is 0, `rd_valid` is 0 and `req_ready` is 0. One cycle after a reset edge, the same values are present on the outputs.
- R2: `mem_ld_n` is never low in two consecutive cycles. `req_ready` is low in every cycle in which a command is on the pins. Two requests of the same kind issued back to back are therefore accepted two cycles apart.
- R3: A request accepted at a clock edge is on the pins during the next cycle: `mem_ld_n`=0, `mem_addr` equal to the request address, and `mem_rw_n`=1 for a read or 0 for a write.
- R4: For a write command in cycle c, `mem_wdata` carries beats 0–1 (`req_wdata[2*DW-1:0]`) in cycle c+1 and beats 2–3 (`req_wdata[4*DW-1:2*DW]`) in cycle c+2. `mem_wdata_oe` is high in exactly those cycles and low in all others.
- R5: For a read command in cycle c, the memory presents beats 0–1 on `mem_rdata` in cycle c+RD_LAT and beats 2–3 in cycle c+RD_LAT+1. The block returns each pair on `rd_data` with `rd_valid` high one cycle later. Pairs come back in command order, so a rising `rd_valid` always lasts at least two cycles.
- R6: A write command follows a read command by at least RD_LAT+2 cycles, which leaves one idle bus cycle after the read data. While this window is open, `req_ready` is low for a write request, and read requests are still accepted.
- R7: A read may follow a write at the minimum spacing of two cycles.
- R8: A command appears on the pins only for a request accepted at the previous edge. With no request pending, `mem_ld_n` stays high. Once all spacing windows have expired, `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one K cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | AW | Burst address |
| req_wdata | input | 4*DW | Four write beats, beat 0 in the low bits |
| rd_valid | output | 1 | Read beat pair valid |
| rd_data | output | 2*DW | Read beat pair, earlier beat in the low bits |
| mem_ld_n | output | 1 | Load strobe, active low; high = deselect |
| mem_rw_n | output | 1 | 1 = read, 0 = write |
| mem_addr | output | AW | Burst address to the memory |
| mem_wdata | output | 2*DW | Write beat pair driven to the shared bus |
| mem_wdata_oe | output | 1 | Write driver enable for the shared bus |
| mem_rdata | input | 2*DW | Read beat pair from the shared bus |

## Verification
The bench builds the block with DW=8, AW=5 and RD_LAT=3. The small address space means random reads often hit addresses that earlier random writes filled, so the late-write placement is checked through the data that later comes back. The larger read latency opens a five-cycle read-to-write window and lengthens the read tag pipe. The memory model in the bench captures write pairs only in their expected slots and drives read pairs only in their expected cycles, so any slip of one cycle shows up as wrong data or as a bus overlap.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
  // Encoding of the read/write select pin
  localparam logic RW_WR = 1'b0;
  localparam logic RW_RD = 1'b1;
  // Beats moved per command and beats carried per clock
  localparam int BEATS      = 4;
  localparam int BEAT_PAIRS = BEATS / 2;
endpackage

// File: rtl/qb4_issue.sv
module qb4_issue
  import qb4_pkg::*;
#(
  parameter int AW     = 20,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          wr_take,
  output logic          issue_rd,
  output logic          mem_ld_n,
  output logic          mem_rw_n,
  output logic [AW-1:0] mem_addr
);
  // Writes stay blocked from the read command cycle until the read data
  // has left the bus and one idle cycle has passed.
  localparam int TA_SPAN = RD_LAT + 1;
  localparam int TW      = $clog2(TA_SPAN + 1);

  logic          cmd_q;
  logic [TW-1:0] ta_cnt;
  logic          wr_blocked;
  logic          take;

  assign wr_blocked = (ta_cnt != '0);
  assign req_ready  = !rst && !cmd_q && !(req_write && wr_blocked);
  assign take       = req_valid && req_ready;
  assign wr_take    = take && req_write;
  assign issue_rd   = cmd_q && (mem_rw_n == RW_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= 1'b0;
      mem_ld_n <= 1'b1;
      mem_rw_n <= RW_RD;
      mem_addr <= '0;
      ta_cnt   <= '0;
    end else begin
      cmd_q    <= take;
      mem_ld_n <= !take;
      if (take) begin
        mem_rw_n <= req_write ? RW_WR : RW_RD;
        mem_addr <= req_addr;
      end else begin
        mem_rw_n <= RW_RD;
      end
      if (take && !req_write)
        ta_cnt <= TW'(TA_SPAN);
      else if (wr_blocked)
        ta_cnt <= ta_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/qb4_wpath.sv
module qb4_wpath
  import qb4_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_take,
  input  logic [BEATS*DW-1:0]  req_wdata,
  output logic [2*DW-1:0]      mem_wdata,
  output logic                 mem_wdata_oe
);
  localparam int PW = 2 * DW;
  localparam int BW = BEATS * DW;

  logic [BW-1:0]         wbuf;
  logic [BEAT_PAIRS-1:0] slot;   // slot[k]: pair k goes out at the next edge

  // Holding register without reset, so it maps onto plain fabric flops.
  always_ff @(posedge clk) begin
    if (wr_take) wbuf <= req_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot         <= '0;
      mem_wdata    <= '0;
      mem_wdata_oe <= 1'b0;
    end else begin
      slot         <= {slot[BEAT_PAIRS-2:0], wr_take};
      mem_wdata_oe <= |slot;
      if (slot[0])
        mem_wdata <= wbuf[PW-1:0];
      else if (slot[1])
        mem_wdata <= wbuf[BW-1:PW];
      else
        mem_wdata <= '0;
    end
  end
endmodule

// File: rtl/qb4_rpath.sv
module qb4_rpath #(
  parameter int DW     = 18,
  parameter int RD_LAT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_rd,
  input  logic [2*DW-1:0] mem_rdata,
  output logic            rd_valid,
  output logic [2*DW-1:0] rd_data
);
  localparam int DEPTH = RD_LAT + 1;

  // tag[k] is high k cycles after a read command cycle
  logic [DEPTH:1] tag;
  logic           capture;

  always_ff @(posedge clk) begin
    if (rst) tag <= '0;
    else     tag <= {tag[DEPTH-1:1], issue_rd};
  end

  assign capture = tag[RD_LAT] | tag[RD_LAT + 1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= mem_rdata;
    end
  end
endmodule

// File: rtl/qb4_sched.sv
module qb4_sched
  import qb4_pkg::*;
#(
  parameter int DW     = 18,
  parameter int AW     = 20,
  parameter int RD_LAT = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [BEATS*DW-1:0] req_wdata,
  output logic                rd_valid,
  output logic [2*DW-1:0]     rd_data,
  output logic                mem_ld_n,
  output logic                mem_rw_n,
  output logic [AW-1:0]       mem_addr,
  output logic [2*DW-1:0]     mem_wdata,
  output logic                mem_wdata_oe,
  input  logic [2*DW-1:0]     mem_rdata
);
  logic wr_take;
  logic issue_rd;

  qb4_issue #(.AW(AW), .RD_LAT(RD_LAT)) u_issue (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .wr_take   (wr_take),
    .issue_rd  (issue_rd),
    .mem_ld_n  (mem_ld_n),
    .mem_rw_n  (mem_rw_n),
    .mem_addr  (mem_addr)
  );

  qb4_wpath #(.DW(DW)) u_wpath (
    .clk          (clk),
    .rst          (rst),
    .wr_take      (wr_take),
    .req_wdata    (req_wdata),
    .mem_wdata    (mem_wdata),
    .mem_wdata_oe (mem_wdata_oe)
  );

  qb4_rpath #(.DW(DW), .RD_LAT(RD_LAT)) u_rpath (
    .clk       (clk),
    .rst       (rst),
    .issue_rd  (issue_rd),
    .mem_rdata (mem_rdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/qb4_sched_chk.sv
module qb4_sched_chk #(
  parameter int RD_LAT = 2
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic mem_ld_n,
  input logic mem_rw_n,
  input logic mem_wdata_oe,
  input logic rd_valid
);
  localparam int LIM = RD_LAT + 2;
  localparam int CW  = $clog2(LIM + 1);

  // Cycles since the last read command, saturating at LIM
  logic [CW-1:0] since_rd;

  always_ff @(posedge clk) begin
    if (rst)
      since_rd <= '0;
    else if (!mem_ld_n && mem_rw_n)
      since_rd <= CW'(1);
    else if (since_rd != '0 && since_rd != CW'(LIM))
      since_rd <= since_rd + 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (mem_ld_n && !mem_wdata_oe && !rd_valid)); // R1

  AST_NO_ADJ_CMD: assert property (@(posedge clk) disable iff (rst)
    !mem_ld_n |=> mem_ld_n); // R2

  AST_READY_LOW_ON_CMD: assert property (@(posedge clk) disable iff (rst)
    !mem_ld_n |-> !req_ready); // R2

  AST_WR_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (!mem_ld_n && !mem_rw_n) |=> mem_wdata_oe); // R4

  AST_OE_HAS_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_wdata_oe |-> ($past(!mem_ld_n && !mem_rw_n) || $past(!mem_ld_n && !mem_rw_n, 2))); // R4

  AST_RD_PAIR: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |=> rd_valid); // R5

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    (!mem_ld_n && !mem_rw_n) |-> (since_rd == '0 || since_rd == CW'(LIM))); // R6

  AST_CMD_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    !mem_ld_n |-> $past(req_valid && req_ready)); // R8
endmodule

bind qb4_sched qb4_sched_chk #(.RD_LAT(RD_LAT)) u_qb4_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .mem_ld_n     (mem_ld_n),
  .mem_rw_n     (mem_rw_n),
  .mem_wdata_oe (mem_wdata_oe),
  .rd_valid     (rd_valid)
);

// File: tb/test_qb4_sched.sv
module test_qb4_sched;
  localparam int DW = 8;
  localparam int AW = 5;
  localparam int RL = 3;
  localparam int PW = 2 * DW;
  localparam int BW = 4 * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [BW-1:0] req_wdata = '0;
  logic          rd_valid;
  logic [PW-1:0] rd_data;
  logic          mem_ld_n;
  logic          mem_rw_n;
  logic [AW-1:0] mem_addr;
  logic [PW-1:0] mem_wdata;
  logic          mem_wdata_oe;
  logic [PW-1:0] mem_rdata = '0;

  always #4 clk = ~clk;

  qb4_sched #(.DW(DW), .AW(AW), .RD_LAT(RL)) i_qb4_sched (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_ld_n(mem_ld_n),
    .mem_rw_n(mem_rw_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard state
  typedef struct { bit wr; int addr; int acc; } cmd_t;
  cmd_t          cmd_q[$];
  logic [PW-1:0] exp_q[$];
  logic [BW-1:0] ref_mem[int];

  // Memory model state
  logic [BW-1:0] mem_arr[int];
  logic [PW-1:0] rsched[int];
  int            wcap_a[int];
  int            wcap_p[int];
  bit            prev_ld = 1;
  bit            rd_bus1 = 0;
  bit            rd_bus2 = 0;

  always @(posedge clk) begin
    if (rst) begin
      prev_ld   <= 1;
      rd_bus1   <= 0;
      rd_bus2   <= 0;
      mem_rdata <= '0;
    end else begin
      if (mem_wdata_oe)
        chk(!rd_bus1 && !rd_bus2, "R6 write driver overlaps read data or its idle cycle",
            {rd_bus1, rd_bus2}, 0);
      if (!mem_ld_n)
        chk(prev_ld, "R2 commands in adjacent cycles", 0, 1);
      prev_ld <= mem_ld_n;
      if (wcap_a.exists(cyc)) begin
        logic [BW-1:0] t;
        int a;
        int p;
        a = wcap_a[cyc];
        p = wcap_p[cyc];
        chk(mem_wdata_oe == 1'b1, "R4 write pair slot without enable", mem_wdata_oe, 1);
        t = mem_arr.exists(a) ? mem_arr[a] : '0;
        t[p*PW +: PW] = mem_wdata;
        mem_arr[a] = t;
        wcap_a.delete(cyc);
        wcap_p.delete(cyc);
      end else if (mem_wdata_oe) begin
        chk(0, "R4 write enable outside a data slot", 1, 0);
      end
      if (!mem_ld_n) begin
        if (cmd_q.size() == 0) begin
          chk(0, "R8 command with no accepted request", {mem_rw_n, mem_addr}, 0);
        end else begin
          cmd_t c;
          logic [BW-1:0] d;
          c = cmd_q.pop_front();
          chk(mem_rw_n == !c.wr && mem_addr == c.addr[AW-1:0], "R3 command pins",
              {mem_rw_n, mem_addr}, {!c.wr, c.addr[AW-1:0]});
          chk(cyc == c.acc + 1, "R3 command cycle", cyc, c.acc + 1);
          if (c.wr) begin
            wcap_a[cyc+1] = c.addr; wcap_p[cyc+1] = 0;
            wcap_a[cyc+2] = c.addr; wcap_p[cyc+2] = 1;
          end else begin
            d = mem_arr.exists(c.addr) ? mem_arr[c.addr] : '0;
            rsched[cyc+RL-1] = d[PW-1:0];
            rsched[cyc+RL]   = d[BW-1:PW];
          end
        end
      end
      if (rsched.exists(cyc)) begin
        mem_rdata <= rsched[cyc];
        rsched.delete(cyc);
        rd_bus1 <= 1;
      end else begin
        mem_rdata <= '0;
        rd_bus1 <= 0;
      end
      rd_bus2 <= rd_bus1;
    end
  end

  // Monitor: read pairs in order against the reference (R5)
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5 read pair with nothing outstanding", rd_data, 0);
      end else begin
        logic [PW-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R5 read pair data", rd_data, e);
      end
    end
  end

  task automatic send(input bit wr, input logic [AW-1:0] a, input logic [BW-1:0] d, output int acc);
    bit hs;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      #1 hs = req_ready;
      @(posedge clk);
      if (hs) break;
      @(negedge clk);
    end
    acc = cyc;
    cmd_q.push_back('{wr, int'(a), acc});
    if (wr) begin
      ref_mem[int'(a)] = d;
    end else begin
      logic [BW-1:0] r;
      r = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
      exp_q.push_back(r[PW-1:0]);
      exp_q.push_back(r[BW-1:PW]);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    int a0, a1, a2, a3, a4;
    bit ld_ok;
    rst = 1;
    repeat (3) @(negedge clk);
    chk(mem_ld_n == 1 && mem_wdata_oe == 0 && rd_valid == 0 && req_ready == 0,
        "R1 reset outputs", {mem_ld_n, mem_wdata_oe, rd_valid, req_ready}, 4'b1000);
    rst = 0;
    idle(2);
    chk(req_ready == 1, "R8 ready when free", req_ready, 1);

    send(1, 5'd3, 32'hA1B2C3D4, a0);
    send(0, 5'd3, '0, a1);
    chk(a1 - a0 == 2, "R7 write-to-read spacing", a1 - a0, 2);
    send(0, 5'd4, '0, a2);
    chk(a2 - a1 == 2, "R2 read-to-read spacing", a2 - a1, 2);
    send(1, 5'd4, 32'h0BADF00D, a3);
    chk(a3 - a2 == RL + 2, "R6 read-to-write spacing", a3 - a2, RL + 2);
    send(1, 5'd6, 32'h12345678, a4);
    chk(a4 - a3 == 2, "R2 write-to-write spacing", a4 - a3, 2);
    send(0, 5'd4, '0, a0);
    idle(3);
    ld_ok = 1;
    repeat (10) begin
      @(negedge clk);
      if (!mem_ld_n) ld_ok = 0;
    end
    chk(ld_ok, "R8 deselect while idle", !ld_ok, 0);
    chk(req_ready == 1, "R8 ready after windows expire", req_ready, 1);

    for (int i = 0; i < 400; i++) begin
      int acc;
      send(1'($urandom_range(0, 1)), AW'($urandom_range(0, (1 << AW) - 1)), BW'($urandom), acc);
      if ($urandom_range(0, 7) == 0) idle($urandom_range(1, 4));
    end
    idle(30);
    chk(exp_q.size() == 0 && cmd_q.size() == 0, "R5 all reads returned",
        exp_q.size() + cmd_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R8 run did not complete actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule